// File: doc/BRIEF.md
# Register Rename Map Table

This block translates architectural register numbers into physical register numbers for an out-of-order core. Integer and floating-point architectural registers share one numbering: the lowest indices are integer registers, the next group holds floating-point registers, and everything above that is a miscellaneous register. Each integer or floating-point entry holds the physical register that currently backs it. At reset, the integer entries point at a consecutive run of physical registers that begins at an integer base. The floating-point entries point at a run that begins at a floating-point base.

A rename request hands out a fresh physical register from the pool of the register's class and reports the mapping it replaced. Each class has one zero register that is never renamed. Miscellaneous registers are never renamed either: they map to fixed slots above all physical registers. The physical registers themselves come from an external free list. The free list offers one register per pool together with an availability flag, and this block pulses a take strobe when it consumes that register. A lookup port reads the current mapping. A set-entry port overwrites a mapping during recovery. Freed physical registers are steered back to the right pool, and a capacity output reports how many more renames are certain to succeed.

Top module: `regmap_rename`

## Requirements
- R1: After reset, integer entry i maps to physical INT_BASE+i, and floating-point entry N_INT_LOG+j maps to physical FP_BASE+j.
- R2: A rename of a non-zero integer register (index below N_INT_LOG) presents `int_grant` on `ren_new` and the entry's current mapping on `ren_prev`, pulses `int_take` in the accepting cycle, and stores the new mapping from the next cycle on.
- R3: A rename of a non-zero floating-point register (index from N_INT_LOG up to N_INT_LOG+N_FP_LOG-1) presents `fp_grant`+N_INT_PHYS on `ren_new`, a value in [N_INT_PHYS, N_INT_PHYS+N_FP_PHYS). It reports the old mapping on `ren_prev`, pulses `fp_take`, and stores the new mapping.
- R4: A rename of INT_ZERO or FP_ZERO puts the register's own architectural index on `ren_new` and its current mapping on `ren_prev`. It pulses no take strobe and leaves the table unchanged.
- R5: For an index a at or above N_INT_LOG+N_FP_LOG, both rename outputs and the lookup output equal a-(N_INT_LOG+N_FP_LOG)+(N_INT_PHYS+N_FP_PHYS), with no take strobe.
- R6: `ren_ready` is low when the pool that the requested register's class needs reports no availability. Zero-register and miscellaneous renames are ready whatever the pools report. A take strobe appears only when a request is accepted.
- R7: `lk_phys` follows `lk_arch` in the same cycle. If a rename of the same entry is accepted in that cycle, the lookup returns the mapping from before the rename.
- R8: A set-entry write to an integer or floating-point index replaces that mapping from the next cycle on. A set-entry write to a miscellaneous index changes no lookup result. While `set_valid` is high, `ren_ready` is low.
- R9: `cap_left` equals the smaller of `int_free_cnt` and `fp_free_cnt`.
- R10: A released physical index p below N_INT_PHYS returns to the integer pool as p. An index from N_INT_PHYS to N_INT_PHYS+N_FP_PHYS-1 returns to the floating-point pool as p-N_INT_PHYS. A higher index returns to neither pool.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_arch | input | AW | Architectural index to rename |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_new | output | PW | Physical register assigned by the rename |
| ren_prev | output | PW | Physical register mapped before the rename |
| lk_arch | input | AW | Architectural index to look up |
| lk_phys | output | PW | Current physical mapping of lk_arch |
| set_valid | input | 1 | Direct mapping write present |
| set_arch | input | AW | Architectural index to overwrite |
| set_phys | input | PW | Physical index to store |
| int_avail | input | 1 | Integer pool has a register on offer |
| int_grant | input | IPW | Integer register on offer |
| int_take | output | 1 | Integer register consumed |
| fp_avail | input | 1 | Floating-point pool has a register on offer |
| fp_grant | input | FPW | Floating-point register on offer, pool-local index |
| fp_take | output | 1 | Floating-point register consumed |
| rel_valid | input | 1 | A physical register is being freed |
| rel_phys | input | PW | Physical index being freed |
| int_ret_valid | output | 1 | Freed register goes to the integer pool |
| int_ret_idx | output | IPW | Integer pool index of the freed register |
| fp_ret_valid | output | 1 | Freed register goes to the floating-point pool |
| fp_ret_idx | output | FPW | Floating-point pool index of the freed register |
| int_free_cnt | input | CW | Free integer registers |
| fp_free_cnt | input | CW | Free floating-point registers |
| cap_left | output | CW | Renames guaranteed to succeed |

## Verification
Rename is tried on every architectural index in two passes with different grant patterns. The first pass tells the reset mapping apart from a stale one, and the second shows that `ren_prev` reports the mapping written by the first pass. Sweeping the two availability flags across one register of each kind (zero, integer, floating-point, miscellaneous) shows that stalls follow the requested register's class. Set-entry writes cover every index while a rename is held pending, so a write that wrongly lands on a miscellaneous index would show up in a lookup sweep afterwards. Exhaustive sweeps of both free counts and of every releasable physical index test the capacity minimum and the pool boundaries.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    ZN_INT  = 2'd0,
    ZN_FP   = 2'd1,
    ZN_MISC = 2'd2
  } rn_zone_e;
endpackage

// File: rtl/rn_zone_decode.sv
module rn_zone_decode
  import rn_pkg::*;
#(
  parameter int N_INT_LOG = 8,
  parameter int N_FP_LOG  = 8,
  parameter int AW        = 5
) (
  input  logic [AW-1:0] arch,
  output rn_zone_e      zone
);
  localparam int NL = N_INT_LOG + N_FP_LOG;

  always_comb begin
    if (int'(arch) < N_INT_LOG)  zone = ZN_INT;
    else if (int'(arch) < NL)    zone = ZN_FP;
    else                         zone = ZN_MISC;
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int N_INT_LOG = 8,
  parameter int N_FP_LOG  = 8,
  parameter int PW        = 6,
  parameter int INT_BASE  = 0,
  parameter int FP_BASE   = 16,
  parameter int TW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] rd0_idx,
  output logic [PW-1:0] rd0_data,
  input  logic [TW-1:0] rd1_idx,
  output logic [PW-1:0] rd1_data,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_idx,
  input  logic [PW-1:0] wr_data
);
  localparam int NL = N_INT_LOG + N_FP_LOG;

  logic [PW-1:0] mem [NL];

  function automatic logic [PW-1:0] boot_map(input int e);
    if (e < N_INT_LOG) return PW'(INT_BASE + e);
    return PW'(FP_BASE + e - N_INT_LOG);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NL; e++) mem[e] <= boot_map(e);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd0_data = mem[rd0_idx];
  assign rd1_data = mem[rd1_idx];

  // R2: a write issued in one cycle is visible in storage the next
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rst_n) |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/rn_release_route.sv
module rn_release_route #(
  parameter int N_INT_PHYS = 16,
  parameter int N_FP_PHYS  = 16,
  parameter int PW         = 6,
  parameter int IPW        = 4,
  parameter int FPW        = 4,
  parameter int CW         = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rel_valid,
  input  logic [PW-1:0]  rel_phys,
  output logic           int_ret_valid,
  output logic [IPW-1:0] int_ret_idx,
  output logic           fp_ret_valid,
  output logic [FPW-1:0] fp_ret_idx,
  input  logic [CW-1:0]  int_cnt,
  input  logic [CW-1:0]  fp_cnt,
  output logic [CW-1:0]  cap_left
);
  localparam int NP = N_INT_PHYS + N_FP_PHYS;

  function automatic logic [FPW-1:0] fp_local(input logic [PW-1:0] p);
    return FPW'(int'(p) - N_INT_PHYS);
  endfunction

  logic in_int_range, in_fp_range;

  assign in_int_range  = int'(rel_phys) < N_INT_PHYS;
  assign in_fp_range   = !in_int_range && (int'(rel_phys) < NP);
  assign int_ret_valid = rel_valid && in_int_range;
  assign fp_ret_valid  = rel_valid && in_fp_range;
  assign int_ret_idx   = IPW'(rel_phys);
  assign fp_ret_idx    = fp_local(rel_phys);
  assign cap_left      = (int_cnt < fp_cnt) ? int_cnt : fp_cnt;

  // R10: a freed register goes to at most one pool
  assert_single_pool_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_ret_valid && fp_ret_valid));

  // R9: capacity never exceeds either pool and matches one of them
  assert_cap_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_left <= int_cnt) && (cap_left <= fp_cnt) &&
    ((cap_left == int_cnt) || (cap_left == fp_cnt)));
endmodule

// File: rtl/regmap_rename.sv
module regmap_rename
  import rn_pkg::*;
#(
  parameter int N_INT_LOG  = 8,
  parameter int N_FP_LOG   = 8,
  parameter int N_MISC     = 4,
  parameter int N_INT_PHYS = 16,
  parameter int N_FP_PHYS  = 16,
  parameter int INT_ZERO   = 0,
  parameter int FP_ZERO    = 8,
  parameter int INT_BASE   = 0,
  parameter int FP_BASE    = 16,
  parameter int AW  = $clog2(N_INT_LOG + N_FP_LOG + N_MISC),
  parameter int PW  = $clog2(N_INT_PHYS + N_FP_PHYS + N_MISC),
  parameter int IPW = $clog2(N_INT_PHYS),
  parameter int FPW = $clog2(N_FP_PHYS),
  parameter int CW  = $clog2(((N_INT_PHYS > N_FP_PHYS) ? N_INT_PHYS : N_FP_PHYS) + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ren_valid,
  input  logic [AW-1:0]  ren_arch,
  output logic           ren_ready,
  output logic [PW-1:0]  ren_new,
  output logic [PW-1:0]  ren_prev,
  input  logic [AW-1:0]  lk_arch,
  output logic [PW-1:0]  lk_phys,
  input  logic           set_valid,
  input  logic [AW-1:0]  set_arch,
  input  logic [PW-1:0]  set_phys,
  input  logic           int_avail,
  input  logic [IPW-1:0] int_grant,
  output logic           int_take,
  input  logic           fp_avail,
  input  logic [FPW-1:0] fp_grant,
  output logic           fp_take,
  input  logic           rel_valid,
  input  logic [PW-1:0]  rel_phys,
  output logic           int_ret_valid,
  output logic [IPW-1:0] int_ret_idx,
  output logic           fp_ret_valid,
  output logic [FPW-1:0] fp_ret_idx,
  input  logic [CW-1:0]  int_free_cnt,
  input  logic [CW-1:0]  fp_free_cnt,
  output logic [CW-1:0]  cap_left
);
  localparam int NL = N_INT_LOG + N_FP_LOG;
  localparam int NP = N_INT_PHYS + N_FP_PHYS;
  localparam int TW = (NL > 1) ? $clog2(NL) : 1;

  // fixed slot of a miscellaneous register above all physical registers
  function automatic logic [PW-1:0] misc_slot(input logic [AW-1:0] a);
    return PW'(int'(a) - NL + NP);
  endfunction

  // floating-point pool hands out local indices; place them after integers
  function automatic logic [PW-1:0] fp_unified(input logic [FPW-1:0] g);
    return PW'(int'(g) + N_INT_PHYS);
  endfunction

  function automatic logic is_zero_reg(input logic [AW-1:0] a);
    return (int'(a) == INT_ZERO) || (int'(a) == FP_ZERO);
  endfunction

  rn_zone_e ren_zone, lk_zone, set_zone;

  rn_zone_decode #(.N_INT_LOG(N_INT_LOG), .N_FP_LOG(N_FP_LOG), .AW(AW))
    u_ren_zone (.arch(ren_arch), .zone(ren_zone));
  rn_zone_decode #(.N_INT_LOG(N_INT_LOG), .N_FP_LOG(N_FP_LOG), .AW(AW))
    u_lk_zone  (.arch(lk_arch),  .zone(lk_zone));
  rn_zone_decode #(.N_INT_LOG(N_INT_LOG), .N_FP_LOG(N_FP_LOG), .AW(AW))
    u_set_zone (.arch(set_arch), .zone(set_zone));

  // named internal events
  logic          ren_zero, need_int, need_fp, pool_ok, ren_fire, set_hit;
  logic          wr_en;
  logic [TW-1:0] wr_idx;
  logic [PW-1:0] wr_data, ren_rd, lk_rd;

  assign ren_zero  = (ren_zone != ZN_MISC) && is_zero_reg(ren_arch);
  assign need_int  = (ren_zone == ZN_INT) && !ren_zero;
  assign need_fp   = (ren_zone == ZN_FP)  && !ren_zero;
  assign pool_ok   = need_int ? int_avail : (need_fp ? fp_avail : 1'b1);
  assign ren_ready = !set_valid && pool_ok;
  assign ren_fire  = ren_valid && ren_ready;
  assign int_take  = ren_fire && need_int;
  assign fp_take   = ren_fire && need_fp;

  always_comb begin
    if (ren_zone == ZN_MISC) ren_new = misc_slot(ren_arch);
    else if (ren_zero)       ren_new = PW'(ren_arch);
    else if (need_int)       ren_new = PW'(int_grant);
    else                     ren_new = fp_unified(fp_grant);
  end

  assign ren_prev = (ren_zone == ZN_MISC) ? misc_slot(ren_arch) : ren_rd;
  assign lk_phys  = (lk_zone == ZN_MISC)  ? misc_slot(lk_arch)  : lk_rd;

  assign set_hit = set_valid && (set_zone != ZN_MISC);
  assign wr_en   = set_hit || (ren_fire && (need_int || need_fp));
  assign wr_idx  = set_hit ? TW'(set_arch) : TW'(ren_arch);
  assign wr_data = set_hit ? set_phys : ren_new;

  rn_map_table #(
    .N_INT_LOG(N_INT_LOG), .N_FP_LOG(N_FP_LOG), .PW(PW),
    .INT_BASE(INT_BASE), .FP_BASE(FP_BASE), .TW(TW)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(TW'(ren_arch)), .rd0_data(ren_rd),
    .rd1_idx(TW'(lk_arch)),  .rd1_data(lk_rd),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  rn_release_route #(
    .N_INT_PHYS(N_INT_PHYS), .N_FP_PHYS(N_FP_PHYS), .PW(PW),
    .IPW(IPW), .FPW(FPW), .CW(CW)
  ) u_release (
    .clk(clk), .rst_n(rst_n),
    .rel_valid(rel_valid), .rel_phys(rel_phys),
    .int_ret_valid(int_ret_valid), .int_ret_idx(int_ret_idx),
    .fp_ret_valid(fp_ret_valid), .fp_ret_idx(fp_ret_idx),
    .int_cnt(int_free_cnt), .fp_cnt(fp_free_cnt), .cap_left(cap_left)
  );

  // R6: a pool is only drawn from when it offers a register
  assert_int_take_avail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |-> int_avail);
  assert_fp_take_avail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fp_take |-> fp_avail);

  // R6: the two pools are never drawn from in the same cycle
  assert_one_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({int_take, fp_take}) <= 1);

  // R8: a recovery write blocks renaming
  assert_set_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> !ren_ready);

  // R3: floating-point renames land in the floating-point physical range
  assert_fp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fp_take |-> (int'(ren_new) >= N_INT_PHYS) && (int'(ren_new) < NP));

  // R5: miscellaneous registers report one fixed slot above physical space
  assert_misc_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_zone == ZN_MISC) |->
      (ren_new == ren_prev) && (int'(ren_new) >= NP) && !int_take && !fp_take);

  // R4: the integer zero register renames to itself
  assert_int_zero_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_fire && int'(ren_arch) == INT_ZERO) |-> int'(ren_new) == INT_ZERO);
endmodule

// File: tb/regmap_rename_bench.sv
module regmap_rename_bench;
  localparam int NIL = 8, NFL = 8, NM = 4, NIP = 16, NFP = 16;
  localparam int NL = NIL + NFL, NT = NL + NM, NP = NIP + NFP;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ren_valid, ren_ready, set_valid, int_avail, fp_avail;
  logic       int_take, fp_take, rel_valid, int_ret_valid, fp_ret_valid;
  logic [4:0] ren_arch, lk_arch, set_arch;
  logic [5:0] ren_new, ren_prev, lk_phys, set_phys, rel_phys;
  logic [3:0] int_grant, fp_grant, int_ret_idx, fp_ret_idx;
  logic [4:0] int_free_cnt, fp_free_cnt, cap_left;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int mdl [NL];

  always #5 clk = ~clk;

  regmap_rename u_regmap_rename (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_ready(ren_ready),
    .ren_new(ren_new), .ren_prev(ren_prev),
    .lk_arch(lk_arch), .lk_phys(lk_phys),
    .set_valid(set_valid), .set_arch(set_arch), .set_phys(set_phys),
    .int_avail(int_avail), .int_grant(int_grant), .int_take(int_take),
    .fp_avail(fp_avail), .fp_grant(fp_grant), .fp_take(fp_take),
    .rel_valid(rel_valid), .rel_phys(rel_phys),
    .int_ret_valid(int_ret_valid), .int_ret_idx(int_ret_idx),
    .fp_ret_valid(fp_ret_valid), .fp_ret_idx(fp_ret_idx),
    .int_free_cnt(int_free_cnt), .fp_free_cnt(fp_free_cnt), .cap_left(cap_left)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int kind_of(input int a); // 0 zero, 1 int, 2 fp, 3 misc
    if (a >= NL) return 3;
    if (a == 0 || a == NIL) return 0;
    return (a < NIL) ? 1 : 2;
  endfunction

  function automatic int expect_lookup(input int a);
    return (a >= NL) ? (a - NL + NP) : mdl[a];
  endfunction

  task automatic sweep_lookups(input string tag);
    for (int a = 0; a < NT; a++) begin
      @(negedge clk);
      lk_arch = 5'(a);
      #1;
      chk($sformatf("%s lookup arch %0d", tag, a), int'(lk_phys), expect_lookup(a));
    end
  endtask

  task automatic rename_pass(input int salt);
    for (int a = 0; a < NT; a++) begin
      int ig, fg, en, ep, ti, tf, k;
      string tag;
      ig = (a * 3 + 5 + salt) % NIP;
      fg = (a * 5 + 1 + salt) % NFP;
      k  = kind_of(a);
      ti = (k == 1); tf = (k == 2);
      case (k)
        0: begin en = a;            ep = mdl[a]; tag = "R4"; end
        1: begin en = ig;           ep = mdl[a]; tag = "R2"; end
        2: begin en = fg + NIP;     ep = mdl[a]; tag = "R3"; end
        default: begin en = a - NL + NP; ep = en; tag = "R5"; end
      endcase
      @(negedge clk);
      ren_valid = 1'b1; ren_arch = 5'(a); lk_arch = 5'(a);
      int_avail = 1'b1; fp_avail = 1'b1;
      int_grant = 4'(ig); fp_grant = 4'(fg);
      #1;
      chk($sformatf("R6 ready arch %0d", a), int'(ren_ready), 1);
      chk($sformatf("%s new arch %0d", tag, a), int'(ren_new), en);
      chk($sformatf("%s prev arch %0d", tag, a), int'(ren_prev), ep);
      chk($sformatf("%s int_take arch %0d", tag, a), int'(int_take), ti);
      chk($sformatf("%s fp_take arch %0d", tag, a), int'(fp_take), tf);
      chk($sformatf("R7 same-cycle lookup arch %0d", a), int'(lk_phys), expect_lookup(a));
      @(negedge clk);
      ren_valid = 1'b0;
      if (ti || tf) mdl[a] = en;
      #1;
      chk($sformatf("%s stored arch %0d", tag, a), int'(lk_phys), expect_lookup(a));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ren_valid = 0; ren_arch = 0; lk_arch = 0; set_valid = 0; set_arch = 0; set_phys = 0;
    int_avail = 0; fp_avail = 0; int_grant = 0; fp_grant = 0;
    rel_valid = 0; rel_phys = 0; int_free_cnt = 0; fp_free_cnt = 0;
    for (int e = 0; e < NL; e++) mdl[e] = (e < NIL) ? e : (NIP + e - NIL);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset map, R5 misc lookup
    sweep_lookups("R1");

    // R2 R3 R4 R5 R7: two passes, second sees first pass's mappings as prev
    rename_pass(0);
    rename_pass(7);

    // R6: stalls follow the class of the requested register
    for (int av = 0; av < 4; av++) begin
      int picks [5] = '{0, 5, 8, 12, 18};
      for (int s = 0; s < 5; s++) begin
        int a, k, er;
        a = picks[s]; k = kind_of(a);
        er = (k == 1) ? (av & 1) : ((k == 2) ? (av >> 1) : 1);
        @(negedge clk);
        ren_valid = 1'b1; ren_arch = 5'(a);
        int_avail = av[0]; fp_avail = av[1];
        #1;
        chk($sformatf("R6 ready arch %0d avail %0d", a, av), int'(ren_ready), er);
        chk($sformatf("R6 int_take arch %0d avail %0d", a, av), int'(int_take),
            (k == 1) ? er : 0);
        chk($sformatf("R6 fp_take arch %0d avail %0d", a, av), int'(fp_take),
            (k == 2) ? er : 0);
        #1;
        ren_valid = 1'b0;
      end
    end
    int_avail = 1'b1; fp_avail = 1'b1;
    sweep_lookups("R6 unchanged");

    // R8: direct writes, rename held off, misc targets ignored
    for (int a = 0; a < NT; a++) begin
      int sp;
      sp = (a * 7 + 3) % 64;
      @(negedge clk);
      set_valid = 1'b1; set_arch = 5'(a); set_phys = 6'(sp);
      ren_valid = 1'b1; ren_arch = 5'((a % 7) + 1);
      #1;
      chk($sformatf("R8 ready low during set %0d", a), int'(ren_ready), 0);
      chk($sformatf("R8 no take during set %0d", a), int'(int_take), 0);
      @(negedge clk);
      set_valid = 1'b0; ren_valid = 1'b0;
      if (a < NL) mdl[a] = sp;
      lk_arch = 5'(a);
      #1;
      chk($sformatf("R8 set result arch %0d", a), int'(lk_phys), expect_lookup(a));
    end
    sweep_lookups("R8 after sets");

    // R9: capacity is the smaller free count
    for (int i = 0; i <= NIP; i++) begin
      for (int f = 0; f <= NFP; f++) begin
        int_free_cnt = 5'(i); fp_free_cnt = 5'(f);
        #1;
        chk($sformatf("R9 cap %0d/%0d", i, f), int'(cap_left), (i < f) ? i : f);
      end
    end

    // R10: release steering over every physical index
    for (int p = 0; p < 64; p++) begin
      int ei, ef;
      ei = (p < NIP); ef = (p >= NIP && p < NP);
      rel_valid = 1'b1; rel_phys = 6'(p);
      #1;
      chk($sformatf("R10 int valid %0d", p), int'(int_ret_valid), ei);
      chk($sformatf("R10 fp valid %0d", p), int'(fp_ret_valid), ef);
      if (ei != 0) chk($sformatf("R10 int idx %0d", p), int'(int_ret_idx), p);
      if (ef != 0) chk($sformatf("R10 fp idx %0d", p), int'(fp_ret_idx), p - NIP);
    end
    rel_valid = 1'b0;
    #1;
    chk("R10 idle no return", int'(int_ret_valid) + int'(fp_ret_valid), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule